// File: doc/BRIEF.md
# Barrel Shift and Rotate Unit

This block moves the bits of a 16-bit target word in one pass. It serves three families of operation. Plain rotates wrap the bits that leave one end back in at the other end, through a barrel network, and leave the carry flag alone. Carry rotates treat the carry and the word as one 17-bit ring. Shifts do not wrap: the positions they empty are filled with the carry-in value rather than with zero. A second set of outputs gives the carry-out and the sign and zero flags of the result.

The distance comes from one of two places. In the static form it is exactly one bit. In the dynamic form it is the value on an 8-bit count input. By default the unit is purely combinational. A parameter adds one output register stage, for paths that need the result timed.

Top module: `shift_rotate_unit`

## Requirements
- R1: With `op_i`=3'b000 (rotate left), the result is `val_i` rotated left by the count modulo 16, and `carry_o` equals `carry_i`.
- R2: With `op_i`=3'b001 (rotate right), the result is `val_i` rotated right by the count modulo 16, and `carry_o` equals `carry_i`.
- R3: With `op_i`=3'b010 (ring left), `{carry_o,res_o}` is `{carry_i,val_i}` rotated left as a 17-bit ring by the count. A count of 17 or any other multiple of 17 gives back the inputs unchanged.
- R4: With `op_i`=3'b011 (ring right), `{carry_o,res_o}` is `{carry_i,val_i}` rotated right as a 17-bit ring by the count.
- R5: With `op_i`=3'b100 (shift left), the word moves left by the count and every vacated low bit takes `carry_i`. `carry_o` is the last bit shifted out: `val_i[16-k]` for a count k from 1 to 16, and `carry_i` for counts above 16. A count of 16 or more fills the whole result with `carry_i`.
- R6: With `op_i`=3'b101 (shift right), the word moves right by the count and every vacated high bit takes `carry_i`. `carry_o` is the last bit shifted out: `val_i[k-1]` for a count k from 1 to 16, and `carry_i` above that. A count of 16 or more fills the result with `carry_i`.
- R7: With `dyn_i`=0 the count is one, whatever the value on `cnt_i`.
- R8: With `dyn_i`=1 and `cnt_i`=0, every operation returns `val_i` and `carry_i` unchanged.
- R9: With `op_i`=3'b110 or 3'b111, the result is `val_i` and `carry_o` is `carry_i`.
- R10: `neg_o` equals bit 15 of the result. `zero_o` is 1 exactly when the result is zero.
- R11: With `REG_OUT`=1, every output appears one clock after its inputs. An active-low reset clears the result and the carry, and sets `zero_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used only when REG_OUT=1 |
| rst_n | input | 1 | Asynchronous active-low reset |
| val_i | input | 16 | Target word |
| cnt_i | input | 8 | Dynamic count |
| carry_i | input | 1 | Carry flag in |
| op_i | input | 3 | Operation select |
| dyn_i | input | 1 | 1: count from cnt_i, 0: count of one |
| res_o | output | 16 | Result word |
| carry_o | output | 1 | Carry flag out |
| neg_o | output | 1 | Sign of result |
| zero_o | output | 1 | Result is zero |

## Verification
The bench builds two copies side by side: one with REG_OUT=0 and one with REG_OUT=1, both at the default 16-bit width and 8-bit count. Every vector goes to both copies. This brings the combinational result and the one-clock latency of the registered variant into reach, together with its reset values. The 8-bit count reaches 255, so the bench can cover wrap of rotates modulo 16 and modulo 17, and saturated shifts past the word width.

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit #(
  parameter int W       = 16,
  parameter int CNT_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     val_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             carry_i,
  input  logic [2:0]       op_i,
  input  logic             dyn_i,
  output logic [W-1:0]     res_o,
  output logic             carry_o,
  output logic             neg_o,
  output logic             zero_o
);
  localparam logic [CNT_W-1:0] WORD = CNT_W'(W);
  localparam logic [CNT_W-1:0] RING = CNT_W'(W + 1);

  logic [CNT_W-1:0] amt, rot_k, ring_k, sat_k;
  logic [2*W-1:0]   rol_t, ror_t;
  logic [2*W+1:0]   rcl_t, rcr_t;
  logic [2*W:0]     shl_t, shr_t;
  logic             fill_c;
  logic [W-1:0]     nxt_res;
  logic             nxt_c;

  assign amt    = dyn_i ? cnt_i : CNT_W'(1);
  assign rot_k  = amt % WORD;
  assign ring_k = amt % RING;
  assign sat_k  = (amt > WORD) ? WORD : amt;
  assign fill_c = (amt == '0) || (amt > WORD);

  assign rol_t = {val_i, val_i} << rot_k;
  assign ror_t = {val_i, val_i} >> rot_k;
  assign rcl_t = {carry_i, val_i, carry_i, val_i} << ring_k;
  assign rcr_t = {carry_i, val_i, carry_i, val_i} >> ring_k;
  assign shl_t = {1'b0, val_i, {W{carry_i}}} << sat_k;
  assign shr_t = {{W{carry_i}}, val_i, 1'b0} >> sat_k;

  always_comb begin
    nxt_res = val_i;
    nxt_c   = carry_i;
    case (op_i)
      3'b000: nxt_res = rol_t[2*W-1:W];
      3'b001: nxt_res = ror_t[W-1:0];
      3'b010: {nxt_c, nxt_res} = rcl_t[2*W+1:W+1];
      3'b011: {nxt_c, nxt_res} = rcr_t[W:0];
      3'b100: begin
        nxt_res = shl_t[2*W-1:W];
        nxt_c   = fill_c ? carry_i : shl_t[2*W];
      end
      3'b101: begin
        nxt_res = shr_t[W:1];
        nxt_c   = fill_c ? carry_i : shr_t[0];
      end
      default: ;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          res_o   <= '0;
          carry_o <= 1'b0;
        end else begin
          res_o   <= nxt_res;
          carry_o <= nxt_c;
        end
      end
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = &{1'b0, clk, rst_n};
      assign res_o   = nxt_res;
      assign carry_o = nxt_c;
    end
  endgenerate

  assign neg_o  = res_o[W-1];
  assign zero_o = (res_o == '0);
endmodule

module shift_rotate_unit_chk #(
  parameter int W       = 16,
  parameter int CNT_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     val_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             carry_i,
  input logic [2:0]       op_i,
  input logic             dyn_i,
  input logic [W-1:0]     res_o,
  input logic             carry_o,
  input logic             neg_o,
  input logic             zero_o
);
  logic [W-1:0]     d_val;
  logic [CNT_W-1:0] d_cnt;
  logic             d_c, d_dyn, ok;
  logic [2:0]       d_op;

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_val <= '0; d_cnt <= '0; d_c <= 1'b0; d_op <= 3'b110; d_dyn <= 1'b0; ok <= 1'b0;
        end else begin
          d_val <= val_i; d_cnt <= cnt_i; d_c <= carry_i; d_op <= op_i; d_dyn <= dyn_i; ok <= 1'b1;
        end
      end
    end else begin : g_now
      assign d_val = val_i; assign d_cnt = cnt_i; assign d_c = carry_i;
      assign d_op  = op_i;  assign d_dyn = dyn_i; assign ok = 1'b1;
    end
  endgenerate

  assert_rot_carry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && d_op[2:1] == 2'b00) |-> (carry_o == d_c && $countones(res_o) == $countones(d_val)));
  assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && d_dyn && d_cnt == '0) |-> (res_o == d_val && carry_o == d_c));
  assert_shl_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && d_op == 3'b100 && d_dyn && d_cnt >= CNT_W'(W)) |-> (res_o == {W{d_c}}));
  assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && d_op[2:1] == 2'b11) |-> (res_o == d_val && carry_o == d_c));
  assert_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o |-> res_o == '0) and (neg_o == res_o[W-1]));
  assert_ring_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && d_op[2:1] == 2'b01) |-> ($countones({carry_o, res_o}) == $countones({d_c, d_val})));
endmodule

bind shift_rotate_unit shift_rotate_unit_chk #(.W(W), .CNT_W(CNT_W), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_shift_rotate_unit.sv
module sim_shift_rotate_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [15:0] val;
  logic [7:0]  cnt;
  logic        cin, dyn;
  logic [2:0]  op;
  logic [15:0] r0, r1;
  logic        c0, c1, n0, n1, z0, z1;
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_rotate_unit #(.REG_OUT(1'b0)) u0 (.clk(clk), .rst_n(rst_n), .val_i(val), .cnt_i(cnt),
    .carry_i(cin), .op_i(op), .dyn_i(dyn), .res_o(r0), .carry_o(c0), .neg_o(n0), .zero_o(z0));
  shift_rotate_unit #(.REG_OUT(1'b1)) u1 (.clk(clk), .rst_n(rst_n), .val_i(val), .cnt_i(cnt),
    .carry_i(cin), .op_i(op), .dyn_i(dyn), .res_o(r1), .carry_o(c1), .neg_o(n1), .zero_o(z1));

  function automatic logic [16:0] model(input logic [15:0] v, input logic [7:0] k,
                                        input logic c, input logic [2:0] o, input logic d);
    logic [15:0] x = v;
    logic        cc = c;
    logic        t;
    int          n = d ? int'(k) : 1;
    for (int i = 0; i < n; i++) begin
      case (o)
        3'b000: x = {x[14:0], x[15]};
        3'b001: x = {x[0], x[15:1]};
        3'b010: begin t = x[15]; x = {x[14:0], cc}; cc = t; end
        3'b011: begin t = x[0];  x = {cc, x[15:1]}; cc = t; end
        3'b100: begin cc = x[15]; x = {x[14:0], c}; end
        3'b101: begin cc = x[0];  x = {c, x[15:1]}; end
        default: ;
      endcase
    end
    return {cc, x};
  endfunction

  function automatic string tag(input logic [2:0] o, input logic d, input logic [7:0] k);
    if (d && k == 0) return "R8";
    if (!d) return "R7";
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100: return "R5";
      3'b101: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%0d dyn=%0d cnt=%0d val=%h cin=%0d act=%h exp=%h",
               req, op, dyn, cnt, val, cin, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] v, input logic [7:0] k, input logic c,
                       input logic [2:0] o, input logic d);
    logic [16:0] e;
    @(negedge clk);
    val = v; cnt = k; cin = c; op = o; dyn = d;
    e = model(v, k, c, o, d);
    #1;
    check(tag(o, d, k), {2'b00, c0, r0}, {2'b00, e});
    check("R10", {1'b0, n0, z0, 16'h0}, {1'b0, e[15], e[15:0] == 16'h0, 16'h0});
    @(posedge clk); #1;
    check("R11", {n1, z1, c1, r1}, {e[15], e[15:0] == 16'h0, e});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7331));
    val = 16'h0; cnt = 8'h0; cin = 1'b0; op = 3'b0; dyn = 1'b0;
    #(CLK_PERIOD * 2 + 2);
    check("R11", {n1, z1, c1, r1}, {1'b0, 1'b1, 17'h0});
    rst_n = 1'b1;
    apply(16'h8001, 8'd1, 1'b0, 3'b000, 1'b1);
    apply(16'h8001, 8'd17, 1'b1, 3'b000, 1'b1);
    apply(16'h1234, 8'd20, 1'b0, 3'b001, 1'b1);
    apply(16'hA5C3, 8'd17, 1'b1, 3'b010, 1'b1);
    apply(16'hA5C3, 8'd34, 1'b0, 3'b011, 1'b1);
    apply(16'h8000, 8'd1, 1'b0, 3'b010, 1'b1);
    apply(16'h0001, 8'd1, 1'b1, 3'b011, 1'b1);
    apply(16'hF00F, 8'd16, 1'b1, 3'b100, 1'b1);
    apply(16'hF00E, 8'd16, 1'b0, 3'b100, 1'b1);
    apply(16'h1234, 8'd255, 1'b1, 3'b100, 1'b1);
    apply(16'h8001, 8'd16, 1'b0, 3'b101, 1'b1);
    apply(16'h1234, 8'd200, 1'b1, 3'b101, 1'b1);
    apply(16'h4321, 8'd9, 1'b1, 3'b101, 1'b1);
    apply(16'hBEEF, 8'd0, 1'b1, 3'b100, 1'b1);
    apply(16'hBEEF, 8'd0, 1'b0, 3'b011, 1'b1);
    apply(16'h8421, 8'd9, 1'b1, 3'b100, 1'b0);
    apply(16'h8421, 8'd200, 1'b0, 3'b011, 1'b0);
    apply(16'hCAFE, 8'd5, 1'b1, 3'b110, 1'b1);
    apply(16'hCAFE, 8'd5, 1'b0, 3'b111, 1'b1);
    apply(16'h0000, 8'd3, 1'b0, 3'b000, 1'b1);
    for (int i = 0; i < 400; i++) begin
      logic [7:0] k = ($urandom % 4 == 0) ? 8'($urandom % 20) : 8'($urandom);
      apply(16'($urandom), k, 1'($urandom), 3'($urandom), ($urandom % 5) != 0);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule